// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block decides when the rows of a DRAM array are refreshed and holds off the host while a refresh is under way. It owns a retention-interval timer and a row pointer. On each refresh it raises a one-cycle strobe together with the row to restore. The rows are visited in ascending order, and the pointer returns to zero after the last row. Three scheduling policies are available, and each trades host dead time in its own way. The burst policy refreshes every row back to back at the start of each interval. The per-access policy adds one row refresh to the end of every host access. The spread policy spaces single-row refreshes evenly across the interval.

The host raises `host_req` to start an access. An access is accepted in any cycle where `host_stall` is low, and it then occupies `ACC_CYC` cycles. An accepted access always runs to completion. A refresh that becomes pending keeps the host stalled until it has been issued. Whatever the policy, the block guarantees that each interval contains at least one refresh of every row.

The interval length is `CLK_KHZ*RETAIN_US/1000` cycles. With the default parameters this is 200 cycles, a scaled-down retention interval. The spread spacing is that length divided by `ROWS`.

Top module: `dram_refresh_sched`

## Requirements
- R1: When reset is released, `ref_stb`, `host_stall` and `sweep_stb` are low and `ref_row` is 0. The first clock cycle after reset starts an interval, and the policy is sampled from `mode_sel` in that cycle.
- R2: Burst policy is `mode_sel` 0, and value 3 also selects burst. At each interval start, ROWS refreshes are queued. They are issued one per cycle with no gaps, once any access in progress has ended, and `host_stall` stays high from the cycle after the interval start until the last of them.
- R3: Per-access policy is `mode_sel` 1. Every accepted access queues one refresh. That refresh is issued in the cycle that follows the access's last cycle, which is ACC_CYC cycles after acceptance, and the host is stalled in that cycle.
- R4: Spread policy is `mode_sel` 2. One refresh is queued at the interval start and then one every INTV/ROWS cycles, counted from the interval start.
- R5: Each refresh is issued to `ref_row`, and `ref_row` then advances by one. After ROWS-1 it returns to 0. `sweep_stb` is high exactly when row ROWS-1 is refreshed.
- R6: An access is accepted when `host_req` is high and `host_stall` is low, and it lasts ACC_CYC cycles. No refresh is issued while an access is in progress, and `host_stall` is high during its remaining cycles. `host_stall` is also high whenever a queued refresh has not yet been issued.
- R7: A change on `mode_sel` in the middle of an interval has no effect until the next interval start.
- R8: Each interval holds at least ROWS refreshes, so no row goes 2*INTV cycles without a refresh.
- R9: Under the per-access policy, if the interval so far holds fewer than ROWS refreshes at cycle INTV-ROWS-ACC_CYC-2 of the interval, the refresh queue is raised to the shortfall in that cycle.
- R10: An interval lasts exactly CLK_KHZ*RETAIN_US/1000 clock cycles, and intervals follow one another without gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Policy request: 0 burst, 1 per-access, 2 spread, 3 burst |
| host_req | input | 1 | Host asks to start an access |
| host_stall | output | 1 | High while no new access may be accepted |
| ref_stb | output | 1 | One-cycle refresh of the row on `ref_row` |
| ref_row | output | $clog2(ROWS) | Row being refreshed |
| sweep_stb | output | 1 | Refresh of the last row; the pointer wraps next |

## Verification
The hardest condition to reach from the ports is the per-access catch-up. It only happens when the per-access policy has too little traffic to have covered every row by the deadline cycle. The bench reaches it by selecting that policy, letting one interval boundary latch it, and then holding `host_req` low for two whole intervals. The second hard case is a policy change in the middle of an interval. The bench changes `mode_sel` at a point that is not an interval boundary and relies on its cycle-exact reference model to show that the old policy stays in force until the next boundary. Interval-boundary collisions between a queued burst and an access in progress come from random host traffic under the burst policy.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
    typedef enum logic [1:0] {
        POL_BURST      = 2'd0,
        POL_PER_ACCESS = 2'd1,
        POL_SPREAD     = 2'd2,
        POL_BURST_ALT  = 2'd3
    } ref_pol_e;
endpackage

// File: rtl/refresh_timebase.sv
module refresh_timebase #(
    parameter int INTV     = 200,
    parameter int SPACING  = 25,
    parameter int DEADLINE = 187
) (
    input  logic clk,
    input  logic rst_n,
    output logic ivl_start,
    output logic spc_tick,
    output logic dl_hit
);
    localparam int TW = (INTV > 1) ? $clog2(INTV) : 1;
    localparam int SW = (SPACING > 1) ? $clog2(SPACING) : 1;

    typedef struct packed {
        logic [TW-1:0] tmr;
        logic [SW-1:0] spc;
    } tb_state_t;

    tb_state_t q, d;

    always_comb begin
        d = q;
        // interval counter wraps after INTV cycles
        d.tmr = (q.tmr == TW'(INTV - 1)) ? '0 : q.tmr + 1'b1;
        // spacing counter restarts with every interval
        d.spc = ((q.tmr == TW'(INTV - 1)) || (q.spc == SW'(SPACING - 1))) ? '0 : q.spc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign ivl_start = (q.tmr == '0);
    assign spc_tick  = (q.spc == '0);
    assign dl_hit    = (q.tmr == TW'(DEADLINE));
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
    parameter int ROWS = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    adv,
    output logic [$clog2(ROWS)-1:0] row,
    output logic                    wrap
);
    localparam int RW = $clog2(ROWS);

    typedef struct packed {
        logic [RW-1:0] row;
    } rc_state_t;

    rc_state_t q, d;
    logic      at_last;

    always_comb begin
        d       = q;
        at_last = (q.row == RW'(ROWS - 1));
        if (adv) d.row = at_last ? '0 : q.row + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign row  = q.row;
    assign wrap = adv && at_last;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
    import dram_refresh_pkg::*;
#(
    parameter int ROWS      = 8,
    parameter int CLK_KHZ   = 100,
    parameter int RETAIN_US = 2000,
    parameter int ACC_CYC   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              mode_sel,
    input  logic                    host_req,
    output logic                    host_stall,
    output logic                    ref_stb,
    output logic [$clog2(ROWS)-1:0] ref_row,
    output logic                    sweep_stb
);
    localparam int INTV     = CLK_KHZ * RETAIN_US / 1000;
    localparam int SPACING  = INTV / ROWS;
    localparam int DEADLINE = INTV - ROWS - ACC_CYC - 2;
    localparam int OW       = $clog2(4 * ROWS);
    localparam int DW       = $clog2(ROWS + 1);
    localparam int BW       = $clog2(ACC_CYC + 1);

    typedef struct packed {
        ref_pol_e      mode;
        logic [OW-1:0] owe;
        logic [DW-1:0] done;
        logic [BW-1:0] busy;
    } sch_state_t;

    sch_state_t q, d;
    logic ivl_start, spc_tick, dl_hit;
    logic issue, accept;

    refresh_timebase #(.INTV(INTV), .SPACING(SPACING), .DEADLINE(DEADLINE)) u_tb (
        .clk(clk), .rst_n(rst_n),
        .ivl_start(ivl_start), .spc_tick(spc_tick), .dl_hit(dl_hit)
    );

    refresh_row_ctr #(.ROWS(ROWS)) u_rc (
        .clk(clk), .rst_n(rst_n), .adv(issue),
        .row(ref_row), .wrap(sweep_stb)
    );

    always_comb begin
        ref_pol_e      eff;
        logic [OW-1:0] add, owe_n, left;
        logic [DW-1:0] done_base;

        d          = q;
        issue      = (q.busy == '0) && (q.owe != '0);
        host_stall = (q.busy != '0) || (q.owe != '0);
        accept     = host_req && !host_stall;
        eff        = ivl_start ? ref_pol_e'(mode_sel) : q.mode;

        // refresh debt added by the active policy this cycle
        case (eff)
            POL_BURST, POL_BURST_ALT: add = ivl_start ? OW'(ROWS) : '0;
            POL_PER_ACCESS:           add = OW'(accept);
            POL_SPREAD:               add = OW'(spc_tick);
            default:                  add = '0;
        endcase
        owe_n = q.owe - OW'(issue) + add;

        // rows still owed in this interval, for the per-access catch-up
        done_base = ivl_start ? '0 : q.done;
        left      = (done_base >= DW'(ROWS)) ? '0 : OW'(DW'(ROWS) - done_base);
        if (issue && (left != '0)) left = left - 1'b1;
        if ((eff == POL_PER_ACCESS) && dl_hit && (owe_n < left)) owe_n = left;

        d.mode = eff;
        d.owe  = owe_n;
        d.done = (issue && (done_base < DW'(ROWS))) ? done_base + 1'b1 : done_base;
        if (accept)              d.busy = BW'(ACC_CYC - 1);
        else if (q.busy != '0)   d.busy = q.busy - 1'b1;
        else                     d.busy = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{mode: POL_BURST, owe: '0, done: '0, busy: '0};
        else        q <= d;
    end

    assign ref_stb = issue;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
    parameter int ROWS = 8,
    parameter int INTV = 200,
    parameter int BW   = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [1:0]              mode_sel,
    input logic                    ivl_start,
    input logic [1:0]              mode_q,
    input logic [BW-1:0]           busy_q,
    input logic                    host_stall,
    input logic                    ref_stb,
    input logic [$clog2(ROWS)-1:0] ref_row,
    input logic                    sweep_stb
);
    localparam int RW  = $clog2(ROWS);
    localparam int AW  = $clog2(2 * INTV + 2);
    localparam int LIM = 2 * INTV;

    logic [AW-1:0] age [ROWS];
    logic          stale;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) age[r] <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (ref_stb && (ref_row == RW'(r))) age[r] <= '0;
                else if (age[r] < AW'(LIM))         age[r] <= age[r] + 1'b1;
            end
        end
    end

    always_comb begin
        stale = 1'b0;
        for (int r = 0; r < ROWS; r++) if (age[r] >= AW'(LIM)) stale = 1'b1;
    end

    AST_BURST_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ivl_start && ((mode_sel == 2'd0) || (mode_sel == 2'd3))) |=> host_stall); // R2
    AST_REFRESH_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |-> host_stall); // R6
    AST_ACCESS_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q != '0) |-> (host_stall && !ref_stb)); // R6
    AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_stb |=> (ref_row == (($past(ref_row) == RW'(ROWS - 1)) ? '0 : $past(ref_row) + 1'b1))); // R5
    AST_SWEEP_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_stb |-> (ref_stb && (ref_row == RW'(ROWS - 1)))); // R5
    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ivl_start |=> $stable(mode_q)); // R7
    AST_ROW_AGE: assert property (@(posedge clk) disable iff (!rst_n)
        !stale); // R8
endmodule

bind dram_refresh_sched refresh_sched_chk #(.ROWS(ROWS), .INTV(INTV), .BW(BW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ivl_start(ivl_start),
    .mode_q(q.mode), .busy_q(q.busy), .host_stall(host_stall),
    .ref_stb(ref_stb), .ref_row(ref_row), .sweep_stb(sweep_stb)
);

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
    localparam int ROWS = 8;
    localparam int ACC  = 3;
    localparam int INTV = 200;
    localparam int SPC  = INTV / ROWS;
    localparam int DL   = INTV - ROWS - ACC - 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_sel = 2'd0;
    logic       host_req = 1'b0;
    logic       host_stall, ref_stb, sweep_stb;
    logic [2:0] ref_row;

    int checks = 0, fails = 0, cycles = 0;
    string tag = "R1";
    bit traffic = 1'b0;

    always #10 clk = ~clk;

    dram_refresh_sched u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .host_req(host_req),
        .host_stall(host_stall), .ref_stb(ref_stb), .ref_row(ref_row), .sweep_stb(sweep_stb)
    );

    // behavioural reference: refresh debt, interval clock, spacing clock, access timer
    int m_tmr, m_spc, m_row, m_mode, m_owe, m_done, m_busy;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tmr = 0; m_spc = 0; m_row = 0; m_mode = 0; m_owe = 0; m_done = 0; m_busy = 0;
        end else begin
            int iss, acc, eff, add, base, need;
            iss  = (m_busy == 0 && m_owe > 0) ? 1 : 0;
            acc  = (host_req && m_busy == 0 && m_owe == 0) ? 1 : 0;
            eff  = (m_tmr == 0) ? int'(mode_sel) : m_mode;
            add  = 0;
            if ((eff == 0 || eff == 3) && m_tmr == 0) add = ROWS;
            if (eff == 1 && acc == 1) add = 1;
            if (eff == 2 && m_spc == 0) add = 1;
            base = (m_tmr == 0) ? 0 : m_done;
            m_owe = m_owe - iss + add;
            need = ROWS - base - iss;
            if (eff == 1 && m_tmr == DL && m_owe < need) m_owe = need;
            m_done = (base + iss > ROWS) ? ROWS : base + iss;
            m_busy = acc ? ACC - 1 : (m_busy > 0 ? m_busy - 1 : 0);
            if (iss == 1) m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
            m_spc  = (m_tmr == INTV - 1 || m_spc == SPC - 1) ? 0 : m_spc + 1;
            m_tmr  = (m_tmr == INTV - 1) ? 0 : m_tmr + 1;
            m_mode = eff;
        end
    end

    // per-cycle comparison and per-interval coverage count
    int ivl_cnt = 0;
    bit ivl_seen = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            bit e_stb, e_stall, e_sweep;
            e_stb   = (m_busy == 0 && m_owe > 0);
            e_stall = (m_busy != 0 || m_owe != 0);
            e_sweep = e_stb && (m_row == ROWS - 1);
            checks++;
            if (ref_stb !== e_stb || host_stall !== e_stall || sweep_stb !== e_sweep ||
                int'(ref_row) != m_row) begin
                fails++;
                $display("FAIL %s cyc %0d: stb/stall/sweep/row = %b/%b/%b/%0d expected %b/%b/%b/%0d",
                         tag, cycles, ref_stb, host_stall, sweep_stb, ref_row,
                         e_stb, e_stall, e_sweep, m_row);
            end
            if (m_tmr == 0) begin
                if (ivl_seen) begin
                    checks++;
                    if (ivl_cnt < ROWS) begin
                        fails++;
                        $display("FAIL R8: interval refreshes %0d expected >= %0d", ivl_cnt, ROWS);
                    end
                end
                ivl_seen = 1'b1;
                ivl_cnt  = 0;
            end
            if (ref_stb) ivl_cnt++;
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            host_req = traffic ? ($urandom_range(0, 2) != 0) : 1'b0;
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++;
            $display("FAIL watchdog: R1 run not complete after %0d cycles, expected under 20000", cycles);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (ref_stb !== 1'b0 || host_stall !== 1'b0 || ref_row !== 3'd0 || sweep_stb !== 1'b0) begin
            fails++;
            $display("FAIL R1: after reset stb/stall/row/sweep = %b/%b/%0d/%b expected 0/0/0/0",
                     ref_stb, host_stall, ref_row, sweep_stb);
        end
        tag = "R2";  run(INTV);
        tag = "R10"; run(INTV);
        tag = "R6";  traffic = 1'b1; run(2 * INTV);
        tag = "R7";  run(INTV / 3); mode_sel = 2'd1; run(INTV);
        tag = "R3";  run(2 * INTV);
        tag = "R9";  traffic = 1'b0; run(2 * INTV);
        tag = "R7";  run(INTV / 2); mode_sel = 2'd2;
        tag = "R4";  run(2 * INTV);
        tag = "R5";  traffic = 1'b1; run(3 * INTV);
        tag = "R8";  mode_sel = 2'd3; run(2 * INTV);
        tag = "R2";  mode_sel = 2'd0; traffic = 1'b0; run(INTV);
        finish_up();
    end
endmodule